// File: doc/BRIEF.md
# Double-Edge Ten-Bit Line Serializer

This block turns a parallel code word into a single-bit line stream, sending one bit on every edge of its clock. Because the line changes on both edges, the clock runs at half the bit rate: with ten bits per word, five clock cycles carry one word. The word is split between two five-stage shift registers with parallel load. The rising-edge register holds the even-indexed bits. The falling-edge register, which runs on the inverted clock, holds the odd-indexed bits. A two-way selector driven by the clock level merges them onto the line. While one register drives the line, the other moves its next bit into place.

An upstream encoder presents a word and pulses a one-cycle load strobe, already synchronous to this clock. The rising-edge register loads on the edge that samples the strobe. The falling-edge register loads on the falling edge that follows. Both then shift on their next four edges, and shift in zeros after that, so an idle line rests at 0. The word input must stay stable from the strobe edge through that falling edge.

Top module: `ddr_serializer`

## Requirements
- R1: While reset is asserted, and after its release until the first strobe, `ser_o` is 0.
- R2: After a rising edge that samples `load_stb_i` high, `ser_o` carries bit 0 of `word_i` during the high phase that follows. It then carries bits 1 to 9 in ascending order, one per half cycle, each bit exactly once.
- R3: Bits carried while the clock is high are the even-indexed word bits. Bits carried while it is low are the odd-indexed word bits.
- R4: A strobed word of 10'b1011001100 appears on the line as the bit sequence 0,0,1,1,0,0,1,1,0,1 (bit 0 first).
- R5: Strobes spaced exactly five cycles apart produce a gapless stream, with the first bit of each word in the half cycle right after the last bit of the previous word.
- R6: A strobe that arrives before the current word is fully sent discards the rest of that word. The new word starts at bit 0 under the R2 timing.
- R7: Once the ten bits of the last strobed word have been sent, `ser_o` stays 0 until the next strobe.
- R8: Changes on `word_i` after the falling edge that follows a strobe, with no new strobe, have no effect on `ser_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-bit-rate clock; both edges move data |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_stb_i | input | 1 | One-cycle word load strobe, synchronous to clk_i |
| word_i | input | WORD_W (10) | Parallel code word, bit 0 sent first |
| ser_o | output | 1 | Serial line, one bit per clock half |

## Verification
The first bit of a word is due in the high phase right after the rising edge that samples the strobe. Each later bit is due one half cycle after the one before it. Rows reach the line only through the clock-level selector, so each result is due in a specific clock phase. The bench's reference model therefore keeps a queue of pending bits. It captures the strobe and word at each rising edge, and pops one bit per edge. It compares that bit with `ser_o` two nanoseconds after every edge, well clear of both edges. Stimulus changes one nanosecond after a falling edge, so the word is stable whenever either row samples it.

// File: rtl/ser_pkg.sv
package ser_pkg;

    // Row control: write loads the parallel bits, shift moves one stage.
    typedef enum logic {
        ROW_WRITE = 1'b0,
        ROW_SHIFT = 1'b1
    } row_mode_e;

endpackage

// File: rtl/ser_row.sv
module ser_row
    import ser_pkg::*;
#(
    parameter int ROW_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  row_mode_e        mode_i,
    input  logic [ROW_W-1:0] par_i,
    output logic             bit_o
);

    typedef struct packed {
        logic [ROW_W-1:0] data;
    } row_state_t;

    row_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (mode_i == ROW_WRITE) begin
            state_d.data = par_i;
        end else begin
            state_d.data = {1'b0, state_q.data[ROW_W-1:1]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bit_o = state_q.data[0];

    AST_ROW_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == ROW_WRITE) |=> (bit_o == $past(par_i[0]))); // R2

    AST_ROW_SHIFT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == ROW_SHIFT) |=> (bit_o == $past(state_q.data[1]))); // R2

endmodule

// File: rtl/ser_load_ctl.sv
module ser_load_ctl
    import ser_pkg::*;
#(
    parameter int ROW_W = 5
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      load_stb_i,
    output row_mode_e rise_mode_o,
    output row_mode_e fall_mode_o,
    output logic      idle_o
);

    localparam int SLOT_W = $clog2(ROW_W + 1);
    localparam logic [SLOT_W-1:0] SLOT_IDLE = SLOT_W'(ROW_W);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              fall_wr;
    } ctl_state_t;

    ctl_state_t state_d, state_q;

    always_comb begin
        state_d         = state_q;
        state_d.fall_wr = load_stb_i;
        if (load_stb_i) begin
            state_d.slot = '0;
        end else if (state_q.slot != SLOT_IDLE) begin
            state_d.slot = state_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.slot    <= SLOT_IDLE;
            state_q.fall_wr <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rise_mode_o = load_stb_i ? ROW_WRITE : ROW_SHIFT;
    assign fall_mode_o = state_q.fall_wr ? ROW_WRITE : ROW_SHIFT;
    assign idle_o      = (state_q.slot == SLOT_IDLE);

    AST_SLOT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_stb_i |=> (fall_mode_o == ROW_WRITE && !idle_o)); // R6

endmodule

// File: rtl/ddr_serializer.sv
module ddr_serializer
    import ser_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_stb_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              ser_o
);

    localparam int ROW_W = WORD_W / 2;

    logic [ROW_W-1:0] even_bits;
    logic [ROW_W-1:0] odd_bits;
    row_mode_e        rise_mode;
    row_mode_e        fall_mode;
    logic             idle;
    logic             rise_bit;
    logic             fall_bit;
    logic             clk_n;
    logic             mux_sel;

    for (genvar g = 0; g < ROW_W; g++) begin : g_split
        assign even_bits[g] = word_i[2*g];
        assign odd_bits[g]  = word_i[2*g+1];
    end

    assign clk_n = ~clk_i;

    ser_load_ctl #(.ROW_W(ROW_W)) u_ctl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_stb_i  (load_stb_i),
        .rise_mode_o (rise_mode),
        .fall_mode_o (fall_mode),
        .idle_o      (idle)
    );

    ser_row #(.ROW_W(ROW_W)) u_row_rise (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .mode_i (rise_mode),
        .par_i  (even_bits),
        .bit_o  (rise_bit)
    );

    ser_row #(.ROW_W(ROW_W)) u_row_fall (
        .clk_i  (clk_n),
        .rst_ni (rst_ni),
        .mode_i (fall_mode),
        .par_i  (odd_bits),
        .bit_o  (fall_bit)
    );

    // Select 0 passes the rising-edge row (clock high), 1 the falling-edge row.
    assign mux_sel = ~clk_i;
    assign ser_o   = mux_sel ? fall_bit : rise_bit;

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle |-> (rise_bit == 1'b0 && fall_bit == 1'b0)); // R7

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            AST_RST_QUIET: assert (ser_o == 1'b0); // R1
        end
    end

endmodule

// File: tb/ddr_serializer_tb_top.sv
module ddr_serializer_tb_top;

    localparam int WORD_W = 10;
    localparam int ROW_W  = WORD_W / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              stb = 1'b0;
    logic [WORD_W-1:0] word = '0;
    logic              ser;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    finished = 1'b0;
    bit    q[$];

    always #5 clk = ~clk;

    ddr_serializer #(.WORD_W(WORD_W)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .load_stb_i (stb),
        .word_i     (word),
        .ser_o      (ser)
    );

    task automatic check_bit(input bit expv, input string phase);
        n_checks++;
        if (ser !== expv) begin
            n_fail++;
            $display("FAIL %s (%s phase, t=%0t): ser_o actual %b expected %b",
                     cur_req, phase, $time, ser, expv);
        end
    endtask

    // Reference model: queue of pending bits, one popped per clock edge.
    always @(posedge clk) begin
        bit expv;
        if (rst_n && stb) begin
            q.delete();
            for (int i = 0; i < WORD_W; i++) q.push_back(word[i]);
        end
        if (!rst_n) q.delete();
        #2;
        expv = (q.size() > 0) ? q.pop_front() : 1'b0;
        if (!finished) check_bit(expv, "high");
    end

    always @(negedge clk) begin
        bit expv;
        #2;
        expv = (q.size() > 0) ? q.pop_front() : 1'b0;
        if (!finished) check_bit(expv, "low");
    end

    task automatic send(input logic [WORD_W-1:0] w);
        @(negedge clk); #1;
        word = w;
        stb  = 1'b1;
        @(negedge clk); #1;
        stb  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        idle(4);
        #1 rst_n = 1'b1;
        idle(3);

        cur_req = "R4";
        send(10'b1011001100);
        idle(8);

        cur_req = "R2";
        send(10'b0000000001);
        idle(6);
        send(10'b1000000000);
        idle(6);

        cur_req = "R3";
        send(10'b0101010101);
        idle(6);
        send(10'b1010101010);
        idle(6);

        cur_req = "R5";
        send(10'b1110001101);
        idle(ROW_W - 2);
        send(10'b0011110010);
        idle(ROW_W - 2);
        send(10'b1111111111);
        idle(ROW_W - 2);
        send(10'b0110100111);
        idle(7);

        cur_req = "R6";
        send(10'b1111100000);
        idle(1);
        send(10'b0000011111);
        send(10'b1100110011);
        idle(7);

        cur_req = "R8";
        send(10'b1001011010);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1 word = ~word ^ WORD_W'(k);
        end
        idle(4);

        cur_req = "R7";
        send(10'b1111111111);
        idle(12);

        cur_req = "R1";
        @(negedge clk); #1 rst_n = 1'b0;
        idle(3);
        #1 rst_n = 1'b1;
        idle(4);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule